// File: doc/BRIEF.md
# Transition-Based Loss-of-Signal Detector

This block watches a serial line, one bit per clock, and raises an alarm when the line stops toggling. A counter tracks how many bit times have passed since the last bit that differed from the one before it. When that count reaches the selected window length, the alarm is set. Four window lengths can be chosen through a two-bit select. A separate default select gives a window of 3112 bit times.

Once set, the alarm stays high until the selected clear criterion is met. The first criterion depends on a framer next to this block, which sends a one-cycle strobe each time it finds a framing word. The alarm drops on the second such strobe, provided no loss event came between the two strobes. The second criterion is a density check. The alarm drops when the last 32 bit times hold at least 4 transitions.

The alarm is active high and is set by reset. It therefore reports loss until the line has proven itself under the chosen clear mode.

Top module: `los_monitor`

## Requirements
- R1: After reset the alarm output `losAlarm` is 1, and it stays 1 until a clear criterion is met.
- R2: A transition is a bit on `serialIn` that differs from the bit sampled one clock earlier, in either direction. Any transition restarts the quiet count, so a run of window-minus-one equal bits followed by a transition never sets the alarm.
- R3: When `serialIn` holds the same value for a full window of consecutive bit times, `losAlarm` is 1 after the clock edge that samples the next bit.
- R4: The window follows the selects. With `useDefaultWin`=1 the window is WIN_DEFAULT (3112 by default) and `winSel` is ignored. With `useDefaultWin`=0, `winSel` 2'b00, 2'b01, 2'b10 and 2'b11 choose WIN_SEL0..WIN_SEL3, which are 128, 512, 2048 and 4096 by default.
- R5: With `clearMode`=0 (frame mode), one `frameFound` strobe leaves the alarm set. The clock edge that samples a second strobe clears it, provided no loss event occurred after the first strobe.
- R6: In frame mode, a loss event that occurs while the block waits for the second strobe discards the first strobe, so two further strobes are then needed.
- R7: With `clearMode`=1 (density mode), the alarm clears one clock after the 32-bit history first holds 4 or more transitions. Three transitions are not enough.
- R8: The density history spans exactly the last 32 bit times. A transition 32 or more bit times old no longer counts.
- R9: Each mode ignores the other mode's criterion. In density mode `frameFound` strobes do not clear the alarm, and in frame mode a dense transition pattern does not clear it.
- R10: The alarm cannot clear while a loss condition is present. Framing strobes that arrive during an ongoing quiet run leave the alarm set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, one serial bit per rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| serialIn | input | 1 | Recovered serial data bit |
| frameFound | input | 1 | One-cycle strobe from the framer when a framing word is found |
| winSel | input | 2 | Window length select (00/01/10/11) |
| useDefaultWin | input | 1 | 1 selects the default window and overrides `winSel` |
| clearMode | input | 1 | 0 = clear on two framing words, 1 = clear on transition density |
| losAlarm | output | 1 | Loss-of-signal alarm, active high |

## Verification
The bench shrinks the windows to 8, 16, 24 and 32 bit times, with a default window of 20. This lets every select value and the default be driven to exactly one bit below and exactly at its threshold within a few hundred cycles. The density span stays at its real value of 32 with a minimum of 4. Because the largest window equals the span, sparse transition patterns can be held for the whole history without a timeout. The bench can therefore probe the exact age at which a transition leaves the count.

// File: rtl/los_pkg.sv
package los_pkg;

  // Strobes the datapath hands to the control each bit time
  typedef struct packed {
    logic trans;    // current bit differs from previous bit
    logic timeout;  // quiet run has reached the selected window
    logic densOk;   // density history holds enough transitions
  } losStb_t;

  typedef enum logic {
    CLR_FRAME   = 1'b0,
    CLR_DENSITY = 1'b1
  } clrMode_e;

endpackage

// File: rtl/los_datapath.sv
module los_datapath
  import los_pkg::*;
#(
  parameter int WIN_SEL0    = 128,
  parameter int WIN_SEL1    = 512,
  parameter int WIN_SEL2    = 2048,
  parameter int WIN_SEL3    = 4096,
  parameter int WIN_DEFAULT = 3112,
  parameter int DENS_SPAN   = 32,
  parameter int DENS_MIN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  logic [1:0] winSel,
  input  logic       useDefaultWin,
  output losStb_t    stb
);

  localparam int MAX_A   = (WIN_SEL0 > WIN_SEL1) ? WIN_SEL0 : WIN_SEL1;
  localparam int MAX_B   = (WIN_SEL2 > WIN_SEL3) ? WIN_SEL2 : WIN_SEL3;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WIN_MAX = (MAX_C > WIN_DEFAULT) ? MAX_C : WIN_DEFAULT;
  localparam int CNT_W   = $clog2(WIN_MAX + 1);
  localparam int DC_W    = $clog2(DENS_SPAN + 1);

  logic             prevBit;
  logic             isTrans;
  logic [CNT_W-1:0] quietCnt;
  logic [CNT_W-1:0] winLimit;

  // Transition detect against the previously sampled bit
  always_ff @(posedge clk) begin
    if (!rstN) prevBit <= 1'b0;
    else       prevBit <= serialIn;
  end

  assign isTrans = serialIn ^ prevBit;

  // Window length selection
  always_comb begin
    if (useDefaultWin) begin
      winLimit = CNT_W'(WIN_DEFAULT);
    end else begin
      case (winSel)
        2'b00:   winLimit = CNT_W'(WIN_SEL0);
        2'b01:   winLimit = CNT_W'(WIN_SEL1);
        2'b10:   winLimit = CNT_W'(WIN_SEL2);
        default: winLimit = CNT_W'(WIN_SEL3);
      endcase
    end
  end

  // Quiet-run counter, saturating at the window
  always_ff @(posedge clk) begin
    if (!rstN)                   quietCnt <= '0;
    else if (isTrans)            quietCnt <= '0;
    else if (quietCnt < winLimit) quietCnt <= quietCnt + 1'b1;
  end

  // Sliding transition-density history with running count
  logic [DENS_SPAN-1:0] transHist;
  logic [DC_W-1:0]      densCnt;

  generate
    if (DENS_SPAN > 1) begin : g_hist_wide
      always_ff @(posedge clk) begin
        if (!rstN) transHist <= '0;
        else       transHist <= {transHist[DENS_SPAN-2:0], isTrans};
      end
    end else begin : g_hist_one
      always_ff @(posedge clk) begin
        if (!rstN) transHist <= '0;
        else       transHist <= isTrans;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) densCnt <= '0;
    else       densCnt <= densCnt + DC_W'(isTrans) - DC_W'(transHist[DENS_SPAN-1]);
  end

  assign stb.trans   = isTrans;
  assign stb.timeout = (quietCnt >= winLimit);
  assign stb.densOk  = (densCnt >= DC_W'(DENS_MIN));

endmodule

// File: rtl/los_control.sv
module los_control
  import los_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  losStb_t stb,
  input  logic    frameFound,
  input  logic    clearMode,
  output logic    losAlarm
);

  logic     alarmQ;
  logic     firstFrame;
  clrMode_e mode;

  assign mode = clrMode_e'(clearMode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      alarmQ     <= 1'b1;
      firstFrame <= 1'b0;
    end else if (stb.timeout) begin
      alarmQ     <= 1'b1;
      firstFrame <= 1'b0;
    end else if (alarmQ) begin
      if (mode == CLR_DENSITY) begin
        firstFrame <= 1'b0;
        if (stb.densOk) alarmQ <= 1'b0;
      end else if (frameFound) begin
        if (firstFrame) begin
          alarmQ     <= 1'b0;
          firstFrame <= 1'b0;
        end else begin
          firstFrame <= 1'b1;
        end
      end
    end else begin
      firstFrame <= 1'b0;
    end
  end

  assign losAlarm = alarmQ;

endmodule

// File: rtl/los_monitor.sv
module los_monitor
  import los_pkg::*;
#(
  parameter int WIN_SEL0    = 128,
  parameter int WIN_SEL1    = 512,
  parameter int WIN_SEL2    = 2048,
  parameter int WIN_SEL3    = 4096,
  parameter int WIN_DEFAULT = 3112,
  parameter int DENS_SPAN   = 32,
  parameter int DENS_MIN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serialIn,
  input  logic       frameFound,
  input  logic [1:0] winSel,
  input  logic       useDefaultWin,
  input  logic       clearMode,
  output logic       losAlarm
);

  losStb_t stb;

  los_datapath #(
    .WIN_SEL0   (WIN_SEL0),
    .WIN_SEL1   (WIN_SEL1),
    .WIN_SEL2   (WIN_SEL2),
    .WIN_SEL3   (WIN_SEL3),
    .WIN_DEFAULT(WIN_DEFAULT),
    .DENS_SPAN  (DENS_SPAN),
    .DENS_MIN   (DENS_MIN)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .serialIn     (serialIn),
    .winSel       (winSel),
    .useDefaultWin(useDefaultWin),
    .stb          (stb)
  );

  los_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .frameFound(frameFound),
    .clearMode (clearMode),
    .losAlarm  (losAlarm)
  );

endmodule

// File: rtl/los_monitor_chk.sv
module los_monitor_chk (
  input logic clk,
  input logic rstN,
  input logic losAlarm,
  input logic clearMode,
  input logic frameFound,
  input logic timeout,
  input logic densOk
);

  // R3
  timeout_sets_alarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> losAlarm);

  // R1
  rise_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(losAlarm) |-> $past(timeout));

  // R10
  no_clear_in_loss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (losAlarm && timeout) |=> losAlarm);

  // R7
  density_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(losAlarm) && $past(clearMode)) |-> $past(densOk));

  // R5
  frame_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(losAlarm) && !$past(clearMode)) |-> $past(frameFound));

endmodule

bind los_monitor los_monitor_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .losAlarm  (losAlarm),
  .clearMode (clearMode),
  .frameFound(frameFound),
  .timeout   (stb.timeout),
  .densOk    (stb.densOk)
);

// File: tb/los_monitor_tb.sv
module los_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // fields: {winSel[1:0], useDefault, expAlarm, quietLen[11:0]}
  localparam logic [15:0] VEC [NVEC] = '{
    {2'd0, 1'b0, 1'b0, 12'd7},
    {2'd0, 1'b0, 1'b1, 12'd8},
    {2'd1, 1'b0, 1'b0, 12'd15},
    {2'd1, 1'b0, 1'b1, 12'd16},
    {2'd2, 1'b0, 1'b0, 12'd23},
    {2'd2, 1'b0, 1'b1, 12'd24},
    {2'd3, 1'b0, 1'b0, 12'd31},
    {2'd3, 1'b0, 1'b1, 12'd32},
    {2'd3, 1'b1, 1'b0, 12'd19},
    {2'd0, 1'b1, 1'b1, 12'd20}
  };

  logic       clk = 1'b0;
  logic       rstN;
  logic       serialIn;
  logic       frameFound;
  logic [1:0] winSel;
  logic       useDefaultWin;
  logic       clearMode;
  logic       losAlarm;
  logic       lastBit;
  int         nChecks = 0;
  int         nFails  = 0;
  int         cycles  = 0;

  los_monitor #(
    .WIN_SEL0(8), .WIN_SEL1(16), .WIN_SEL2(24), .WIN_SEL3(32),
    .WIN_DEFAULT(20), .DENS_SPAN(32), .DENS_MIN(4)
  ) u_dut (
    .clk(clk), .rstN(rstN), .serialIn(serialIn), .frameFound(frameFound),
    .winSel(winSel), .useDefaultWin(useDefaultWin), .clearMode(clearMode),
    .losAlarm(losAlarm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      nChecks = nChecks + 1;
      nFails  = nFails + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected below 100000", cycles);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    nChecks = nChecks + 1;
    if (act !== exp) begin
      nFails = nFails + 1;
      $display("FAIL %s: losAlarm actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic sendBitF(input logic b, input logic f);
    serialIn   = b;
    frameFound = f;
    lastBit    = b;
    @(posedge clk);
    #1;
    frameFound = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    sendBitF(b, 1'b0);
  endtask

  task automatic toggles(input int n);
    for (int i = 0; i < n; i++) sendBit(~lastBit);
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) sendBit(lastBit);
  endtask

  task automatic doReset(input logic mode, input logic [1:0] sel);
    rstN = 1'b0; serialIn = 1'b0; frameFound = 1'b0; lastBit = 1'b0;
    clearMode = mode; winSel = sel; useDefaultWin = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rstN = 1'b1;
  endtask

  initial begin
    doReset(1'b1, 2'd3);
    check("R1 reset state", losAlarm, 1'b1);

    // Table walk: window thresholds for every select (R2, R3, R4)
    for (int v = 0; v < NVEC; v++) begin
      clearMode = 1'b1;
      winSel = 2'd3; useDefaultWin = 1'b0;
      toggles(40);
      check("R7 density clear before vector", losAlarm, 1'b0);
      winSel        = VEC[v][15:14];
      useDefaultWin = VEC[v][13];
      quiet(int'(VEC[v][11:0]));
      sendBit(~lastBit);
      if (VEC[v][12]) check("R3 R4 alarm at window", losAlarm, 1'b1);
      else            check("R2 R4 no alarm below window", losAlarm, 1'b0);
    end

    // R5: two framing strobes clear; one does not
    doReset(1'b0, 2'd3);
    toggles(5);
    sendBitF(~lastBit, 1'b1);
    toggles(5);
    check("R5 one strobe keeps alarm", losAlarm, 1'b1);
    sendBitF(~lastBit, 1'b1);
    check("R5 second strobe clears", losAlarm, 1'b0);

    // R6: loss event between strobes restarts the sequence
    doReset(1'b0, 2'd0);
    toggles(3);
    sendBitF(~lastBit, 1'b1);
    quiet(9);
    toggles(3);
    sendBitF(~lastBit, 1'b1);
    check("R6 first strobe discarded after loss", losAlarm, 1'b1);
    toggles(2);
    sendBitF(~lastBit, 1'b1);
    check("R6 clears after two fresh strobes", losAlarm, 1'b0);

    // R10: strobes during an ongoing quiet run do not clear
    doReset(1'b0, 2'd0);
    quiet(12);
    sendBitF(lastBit, 1'b1);
    sendBitF(lastBit, 1'b1);
    quiet(2);
    check("R10 no clear while in loss", losAlarm, 1'b1);

    // R7: three transitions insufficient, fourth clears one clock later
    doReset(1'b1, 2'd3);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    quiet(2);
    check("R7 three transitions keep alarm", losAlarm, 1'b1);
    sendBit(1'b0);
    sendBit(1'b0);
    check("R7 fourth transition clears", losAlarm, 1'b0);

    // R8: transition 32 bit times old drops out of the history
    doReset(1'b1, 2'd3);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
    quiet(29);
    sendBit(1'b0);
    quiet(2);
    check("R8 aged transition not counted", losAlarm, 1'b1);

    // R9: density mode ignores framing strobes
    doReset(1'b1, 2'd3);
    for (int k = 0; k < 3; k++) begin
      sendBit(~lastBit);
      quiet(4);
      sendBitF(lastBit, 1'b1);
      quiet(5);
    end
    check("R9 strobes ignored in density mode", losAlarm, 1'b1);

    // R9: frame mode ignores transition density
    doReset(1'b0, 2'd3);
    toggles(40);
    check("R9 density ignored in frame mode", losAlarm, 1'b1);

    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule